// File: doc/BRIEF.md
# Multi-line video output cache

This block sits between a producer running on a system clock and a video output running on the pixel clock. It holds a small number of complete display lines in a dual-clock RAM. The producer writes pixels into line slots. The pixel side reads one slot per visible line in raster order. The slot index forms the top bits of the RAM address and the column forms the lower bits. Each slot is `2**COL_BITS` pixels wide, whatever width the output mode actually uses. With `COL_BITS = 11` a slot holds 2048 pixels, and a 1920-pixel mode leaves the last 128 locations of each slot unused.

On the pixel side, a column counter starts at zero on the first active pixel of each line. A slot counter (`LINE_BITS` wide, 4 slots by default) advances on the horizontal sync that ends a line carrying active video, and returns to zero on vertical sync. The only state sent back to the system clock is the slot counter and the vertical sync. The slot counter is Gray-coded before it crosses, and both signals pass through two-flop synchronizers. From them the system side derives:
- a vertical-sync pulse, on which the producer begins filling slots;
- a per-slot free mask, which tells the producer where it may write;
- a sticky flag, set when a write lands in the slot being displayed.

Top module: `vid_line_cache`

## Requirements
- R1: While both resets are held low, and after they are released, the block is in its reset state:
    - `p_pix`, `p_hs_o`, `p_vs_o`, `p_de_o`, `s_vs_pulse` and `s_overrun` are 0;
    - `s_rd_line` is 0;
    - `s_free` is 1 for every slot except slot 0.
- R2: The pixel at RAM address `{slot, column}` appears on `p_pix` one pixel clock after the `p_de` cycle that reads it. The column is 0 on the first cycle of each run of `p_de` and rises by one on each following active cycle. The slot is the current value of the slot counter.
- R3: `p_hs_o`, `p_vs_o` and `p_de_o` equal `p_hs`, `p_vs` and `p_de` delayed by exactly one pixel clock. `p_pix` is 0 whenever `p_de_o` is 0.
- R4: The slot counter rises by one on a rising edge of `p_hs`, but only if `p_de` was high at some point since the previous rising edge of `p_hs`. A line without active pixels leaves it unchanged.
- R5: While `p_vs` is high, the slot counter is forced to 0. This holds even in the middle of a frame.
- R6: After the synchronizer delay, `s_rd_line` equals the pixel-side slot counter in binary. `s_free` has bit i set for every slot i other than `s_rd_line`.
- R7: Each rising edge of `p_vs` yields exactly one `sclk`-wide pulse on `s_vs_pulse`.
- R8: A write with `s_we` high and `s_line` equal to `s_rd_line` sets `s_overrun`. The flag stays set until `srst_n` is low. Writes to other slots leave it at 0.
- R9: The slot counter wraps from `2**LINE_BITS - 1` to 0, and the next active line reads slot 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| prst_n | input | 1 | Synchronous active-low reset, pixel domain |
| p_hs | input | 1 | Horizontal sync from the raster generator |
| p_vs | input | 1 | Vertical sync from the raster generator |
| p_de | input | 1 | Active-video flag from the raster generator |
| p_hs_o | output | 1 | Horizontal sync, aligned with `p_pix` |
| p_vs_o | output | 1 | Vertical sync, aligned with `p_pix` |
| p_de_o | output | 1 | Active-video flag, aligned with `p_pix` |
| p_pix | output | PIX_W | Pixel read from the cache |
| sclk | input | 1 | System clock |
| srst_n | input | 1 | Synchronous active-low reset, system domain |
| s_we | input | 1 | Write strobe |
| s_line | input | LINE_BITS | Slot to write |
| s_col | input | COL_BITS | Column to write |
| s_pix | input | PIX_W | Pixel to write |
| s_rd_line | output | LINE_BITS | Slot being displayed, as seen in the system domain |
| s_free | output | 2**LINE_BITS | Bit i set when slot i may be written |
| s_vs_pulse | output | 1 | One-cycle pulse per output vertical sync |
| s_overrun | output | 1 | Sticky flag: a write landed in the displayed slot |

## Verification
Pixel data and the delayed sync and active flags are due exactly one pixel clock after the input cycle that caused them. The bench drives inputs on falling edges and checks each result on the next falling edge, so every pixel comparison is made one cycle after its read. Slot-counter effects on the system side pass through one pixel-domain register and two or three system-clock flops. The bench therefore waits twelve idle pixel clocks after each horizontal or vertical sync before it compares `s_rd_line`, `s_free` and the count of `s_vs_pulse` pulses. The overrun flag is checked a full system cycle after the write strobe that sets it.

// File: rtl/vlc_pkg.sv
// Package: shared types and defaults for the video line cache.
// Assumes: nothing beyond the default widths listed here.
package vlc_pkg;
    localparam int unsigned VLC_PIX_W     = 24;
    localparam int unsigned VLC_COL_BITS  = 9;
    localparam int unsigned VLC_LINE_BITS = 2;

    // Sync and active flags that travel together through the output stage.
    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } vlc_sync_t;
endpackage

// File: rtl/vlc_dpram.sv
// Module: simple dual-clock RAM, one write port and one registered read port.
// Assumes: write and read addresses never need to collide in a meaningful way;
// read data carries no reset because the output stage masks it.
module vlc_dpram #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 24
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one pixel per write strobe.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Fetch one pixel per read clock.
    always_ff @(posedge rclk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/vlc_pix_side.sv
// Module: pixel-clock side of the line cache. It forms the read address from
// a column counter and a slot counter, and aligns the sync flags with the RAM
// output. It also publishes the slot counter in Gray code.
// Assumes: p_de is high only inside the visible area; the RAM read adds one clock.
module vlc_pix_side
    import vlc_pkg::*;
#(
    parameter int unsigned LINE_BITS = 2,
    parameter int unsigned COL_BITS  = 9,
    parameter int unsigned PIX_W     = 24
) (
    input  logic                          pclk,
    input  logic                          prst_n,
    input  logic                          hs_i,
    input  logic                          vs_i,
    input  logic                          de_i,
    input  logic [PIX_W-1:0]              rd_q_i,
    output logic [LINE_BITS+COL_BITS-1:0] raddr_o,
    output logic                          hs_o,
    output logic                          vs_o,
    output logic                          de_o,
    output logic [PIX_W-1:0]              pix_o,
    output logic [LINE_BITS-1:0]          gray_o
);
    logic [COL_BITS-1:0]  col_q;
    logic [LINE_BITS-1:0] line_q;
    logic                 hs_prev_q;
    logic                 had_de_q;
    logic                 hs_rise;
    vlc_sync_t            dly_q;

    assign hs_rise = hs_i & ~hs_prev_q;

    // Column counter: restarts on every blank cycle, counts active pixels.
    always_ff @(posedge pclk) begin
        if (!prst_n || !de_i) begin
            col_q <= '0;
        end else begin
            col_q <= col_q + 1'b1;
        end
    end

    // Remember the previous hsync level for edge detection.
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            hs_prev_q <= 1'b0;
        end else begin
            hs_prev_q <= hs_i;
        end
    end

    // Track whether the current line carried any active pixel.
    always_ff @(posedge pclk) begin
        if (!prst_n || vs_i || hs_rise) begin
            had_de_q <= 1'b0;
        end else if (de_i) begin
            had_de_q <= 1'b1;
        end
    end

    // Slot counter: cleared by vsync, stepped by hsync after an active line.
    always_ff @(posedge pclk) begin
        if (!prst_n || vs_i) begin
            line_q <= '0;
        end else if (hs_rise && (had_de_q || de_i)) begin
            line_q <= line_q + 1'b1;
        end
    end

    // Gray-code the slot counter in a register before it crosses domains.
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            gray_o <= '0;
        end else begin
            gray_o <= line_q ^ (line_q >> 1);
        end
    end

    // Delay the flags by the RAM read latency.
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= '{hs: hs_i, vs: vs_i, de: de_i};
        end
    end

    assign raddr_o = {line_q, col_q};
    assign hs_o    = dly_q.hs;
    assign vs_o    = dly_q.vs;
    assign de_o    = dly_q.de;
    assign pix_o   = dly_q.de ? rd_q_i : '0;

    AST_COL_IDLE_ZERO: assert property (@(posedge pclk) disable iff (!prst_n)
        !de_i |=> (col_q == '0)); // R2
    AST_FLAGS_ALIGNED: assert property (@(posedge pclk) disable iff (!prst_n)
        $past(prst_n) |-> (de_o == $past(de_i) && hs_o == $past(hs_i) && vs_o == $past(vs_i))); // R3
    AST_LINE_STEP: assert property (@(posedge pclk) disable iff (!prst_n)
        (line_q != $past(line_q)) |-> (line_q == LINE_BITS'($past(line_q) + 1'b1) || line_q == '0)); // R4
    AST_VS_CLEARS_LINE: assert property (@(posedge pclk) disable iff (!prst_n)
        vs_i |=> (line_q == '0)); // R5
endmodule

// File: rtl/vlc_sys_side.sv
// Module: system-clock side of the line cache. It synchronizes the Gray slot
// counter and the output vsync, derives the free-slot mask and the vsync pulse,
// and keeps the sticky overrun flag.
// Assumes: the Gray input moves by one step between vsyncs; a vsync reset may
// jump several bits, which the producer covers by waiting for the vsync pulse.
module vlc_sys_side #(
    parameter int unsigned LINE_BITS = 2
) (
    input  logic                      sclk,
    input  logic                      srst_n,
    input  logic [LINE_BITS-1:0]      gray_i,
    input  logic                      vs_i,
    input  logic                      we_i,
    input  logic [LINE_BITS-1:0]      line_i,
    output logic [LINE_BITS-1:0]      rd_line_o,
    output logic [(1<<LINE_BITS)-1:0] free_o,
    output logic                      vs_pulse_o,
    output logic                      overrun_o
);
    logic [LINE_BITS-1:0] g_s1_q;
    logic [LINE_BITS-1:0] g_s2_q;
    logic [2:0]           vs_sh_q;

    // Two-flop synchronizer for the Gray slot counter.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            g_s1_q <= '0;
            g_s2_q <= '0;
        end else begin
            g_s1_q <= gray_i;
            g_s2_q <= g_s1_q;
        end
    end

    // Two-flop synchronizer plus one edge-history flop for vsync.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            vs_sh_q <= '0;
        end else begin
            vs_sh_q <= {vs_sh_q[1:0], vs_i};
        end
    end

    // Convert the synchronized Gray value back to binary.
    always_comb begin
        rd_line_o[LINE_BITS-1] = g_s2_q[LINE_BITS-1];
        for (int i = LINE_BITS - 2; i >= 0; i--) begin
            rd_line_o[i] = rd_line_o[i+1] ^ g_s2_q[i];
        end
    end

    // Every slot except the displayed one may be refilled.
    always_comb begin
        free_o            = '1;
        free_o[rd_line_o] = 1'b0;
    end

    assign vs_pulse_o = vs_sh_q[1] & ~vs_sh_q[2];

    // Sticky flag for writes into the displayed slot.
    always_ff @(posedge sclk) begin
        if (!srst_n) begin
            overrun_o <= 1'b0;
        end else if (we_i && (line_i == rd_line_o)) begin
            overrun_o <= 1'b1;
        end
    end

    AST_OVERRUN_SETS: assert property (@(posedge sclk) disable iff (!srst_n)
        (we_i && line_i == rd_line_o) |=> overrun_o); // R8
    AST_OVERRUN_STICKY: assert property (@(posedge sclk) disable iff (!srst_n)
        overrun_o |=> overrun_o); // R8
    AST_VS_PULSE_SHORT: assert property (@(posedge sclk) disable iff (!srst_n)
        vs_pulse_o |=> !vs_pulse_o); // R7
endmodule

// File: rtl/vid_line_cache.sv
// Module: top of the multi-line video output cache. It ties the dual-clock RAM
// to the pixel-side reader and the system-side status logic.
// Assumes: pclk and sclk are unrelated; the only pixel-to-system signals are
// the Gray slot counter and the registered vsync.
module vid_line_cache
    import vlc_pkg::*;
#(
    parameter int unsigned PIX_W     = VLC_PIX_W,
    parameter int unsigned COL_BITS  = VLC_COL_BITS,
    parameter int unsigned LINE_BITS = VLC_LINE_BITS
) (
    input  logic                      pclk,
    input  logic                      prst_n,
    input  logic                      p_hs,
    input  logic                      p_vs,
    input  logic                      p_de,
    output logic                      p_hs_o,
    output logic                      p_vs_o,
    output logic                      p_de_o,
    output logic [PIX_W-1:0]          p_pix,
    input  logic                      sclk,
    input  logic                      srst_n,
    input  logic                      s_we,
    input  logic [LINE_BITS-1:0]      s_line,
    input  logic [COL_BITS-1:0]       s_col,
    input  logic [PIX_W-1:0]          s_pix,
    output logic [LINE_BITS-1:0]      s_rd_line,
    output logic [(1<<LINE_BITS)-1:0] s_free,
    output logic                      s_vs_pulse,
    output logic                      s_overrun
);
    localparam int unsigned AW = LINE_BITS + COL_BITS;

    logic [AW-1:0]        raddr;
    logic [PIX_W-1:0]     rd_q;
    logic [LINE_BITS-1:0] gray;

    vlc_dpram #(.AW(AW), .DW(PIX_W)) u_ram (
        .wclk  (sclk),
        .we    (s_we),
        .waddr ({s_line, s_col}),
        .wdata (s_pix),
        .rclk  (pclk),
        .raddr (raddr),
        .rdata (rd_q)
    );

    vlc_pix_side #(.LINE_BITS(LINE_BITS), .COL_BITS(COL_BITS), .PIX_W(PIX_W)) u_pix (
        .pclk    (pclk),
        .prst_n  (prst_n),
        .hs_i    (p_hs),
        .vs_i    (p_vs),
        .de_i    (p_de),
        .rd_q_i  (rd_q),
        .raddr_o (raddr),
        .hs_o    (p_hs_o),
        .vs_o    (p_vs_o),
        .de_o    (p_de_o),
        .pix_o   (p_pix),
        .gray_o  (gray)
    );

    vlc_sys_side #(.LINE_BITS(LINE_BITS)) u_sys (
        .sclk       (sclk),
        .srst_n     (srst_n),
        .gray_i     (gray),
        .vs_i       (p_vs_o),
        .we_i       (s_we),
        .line_i     (s_line),
        .rd_line_o  (s_rd_line),
        .free_o     (s_free),
        .vs_pulse_o (s_vs_pulse),
        .overrun_o  (s_overrun)
    );
endmodule

// File: tb/vid_line_cache_test.sv
module vid_line_cache_test;
    localparam int CLK_PERIOD  = 10;
    localparam int SCLK_PERIOD = 14;
    localparam int PW = 24;
    localparam int CB = 9;
    localparam int LB = 2;
    localparam int NS = 1 << LB;
    localparam int NCOL = 8;
    localparam int NROWS = 6;
    // Per line: active pixel count, slot read, slot expected after its hsync.
    localparam int ROW_DE   [NROWS] = '{8, 0, 5, 8, 8, 3};
    localparam int ROW_SLOT [NROWS] = '{0, 1, 1, 2, 3, 0};
    localparam int ROW_NEXT [NROWS] = '{1, 1, 2, 3, 0, 1};

    logic pclk = 0, sclk = 0, prst_n = 0, srst_n = 0;
    logic p_hs = 0, p_vs = 0, p_de = 0;
    logic s_we = 0;
    logic [LB-1:0] s_line = '0;
    logic [CB-1:0] s_col = '0;
    logic [PW-1:0] s_pix = '0;
    logic p_hs_o, p_vs_o, p_de_o, s_vs_pulse, s_overrun;
    logic [PW-1:0] p_pix;
    logic [LB-1:0] s_rd_line;
    logic [NS-1:0] s_free;
    int checks = 0, failures = 0, vs_pulses = 0;

    vid_line_cache #(.PIX_W(PW), .COL_BITS(CB), .LINE_BITS(LB)) uut (
        .pclk(pclk), .prst_n(prst_n), .p_hs(p_hs), .p_vs(p_vs), .p_de(p_de),
        .p_hs_o(p_hs_o), .p_vs_o(p_vs_o), .p_de_o(p_de_o), .p_pix(p_pix),
        .sclk(sclk), .srst_n(srst_n), .s_we(s_we), .s_line(s_line), .s_col(s_col),
        .s_pix(s_pix), .s_rd_line(s_rd_line), .s_free(s_free),
        .s_vs_pulse(s_vs_pulse), .s_overrun(s_overrun)
    );

    always #(CLK_PERIOD / 2) pclk = ~pclk;
    always #(SCLK_PERIOD / 2) sclk = ~sclk;

    always @(negedge sclk) if (s_vs_pulse) vs_pulses++;

    function automatic logic [PW-1:0] pat(input int slot, input int col);
        return {8'(8'hA0 + slot), 8'(col * 3), 8'(8'h5A ^ col)};
    endfunction

    function automatic logic [NS-1:0] free_for(input int slot);
        logic [NS-1:0] m = '1;
        m[slot] = 1'b0;
        return m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic swrite(input int slot, input int col, input logic [PW-1:0] d);
        @(negedge sclk);
        s_we = 1; s_line = LB'(slot); s_col = CB'(col); s_pix = d;
        @(negedge sclk);
        s_we = 0;
    endtask

    task automatic fill_slot(input int slot);
        for (int c = 0; c < NCOL; c++) swrite(slot, c, pat(slot, c));
    endtask

    task automatic vsync_pulse();
        @(negedge pclk); p_vs = 1;
        @(negedge pclk); check("R3 vs delayed", 32'(p_vs_o), 1);
        repeat (2) @(negedge pclk);
        p_vs = 0;
        repeat (12) @(negedge pclk);
    endtask

    // One line: active pixels read from a slot, then an hsync.
    task automatic run_line(input int n, input int slot, input int nxt);
        for (int k = 0; k < n; k++) begin
            @(negedge pclk);
            if (k > 0) check($sformatf("R2 slot%0d col%0d", slot, k - 1), 32'(p_pix), 32'(pat(slot, k - 1)));
            p_de = 1;
        end
        if (n > 0) begin
            @(negedge pclk);
            check($sformatf("R2 slot%0d col%0d", slot, n - 1), 32'(p_pix), 32'(pat(slot, n - 1)));
            check("R3 de delayed high", 32'(p_de_o), 1);
            p_de = 0;
            @(negedge pclk);
            check("R3 de delayed low", 32'(p_de_o), 0);
            check("R3 pix masked", 32'(p_pix), 0);
        end
        @(negedge pclk); p_hs = 1;
        @(negedge pclk);
        check("R3 hs delayed", 32'(p_hs_o), 1);
        p_hs = 0;
        repeat (12) @(negedge pclk);
        check("R4 R9 slot after hsync", 32'(s_rd_line), 32'(nxt));
        check("R6 free mask", 32'(s_free), 32'(free_for(nxt)));
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge sclk);
        prst_n = 1; srst_n = 1;
        repeat (6) @(negedge pclk);
        // R1: reset state
        check("R1 pix", 32'(p_pix), 0);
        check("R1 flags", {29'd0, p_hs_o, p_vs_o, p_de_o}, 0);
        check("R1 rd_line", 32'(s_rd_line), 0);
        check("R1 free", 32'(s_free), 32'(free_for(0)));
        check("R1 overrun", 32'(s_overrun), 0);
        check("R1 vs pulses", 32'(vs_pulses), 0);

        // R8: writes to slots other than the displayed one leave the flag clear
        fill_slot(1); fill_slot(2); fill_slot(3);
        @(negedge sclk);
        check("R8 no overrun", 32'(s_overrun), 0);
        // R8: slot 0 is displayed, so this fill sets the sticky flag
        fill_slot(0);
        repeat (3) @(negedge sclk);
        check("R8 overrun set", 32'(s_overrun), 1);
        repeat (5) @(negedge sclk);
        check("R8 overrun sticky", 32'(s_overrun), 1);
        @(negedge sclk); srst_n = 0;
        repeat (2) @(negedge sclk); srst_n = 1;
        @(negedge sclk);
        check("R8 overrun cleared", 32'(s_overrun), 0);

        // R7: one frame start pulse
        vsync_pulse();
        check("R7 one pulse", 32'(vs_pulses), 1);
        check("R5 slot zero", 32'(s_rd_line), 0);

        // Table walk: R2 R4 R6 R9
        for (int r = 0; r < NROWS; r++) run_line(ROW_DE[r], ROW_SLOT[r], ROW_NEXT[r]);

        // R5: vsync in mid-frame returns to slot 0
        run_line(4, 1, 2);
        vsync_pulse();
        check("R5 mid-frame reset", 32'(s_rd_line), 0);
        check("R6 free after vsync", 32'(s_free), 32'(free_for(0)));
        check("R7 second pulse", 32'(vs_pulses), 2);
        run_line(6, 0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule